// File: doc/BRIEF.md
# Single-Bus Processor Datapath Controller

A compact 32-bit processing core in which every transfer between storage elements travels over one shared internal bus. A hardwired step counter drives one set of control strobes per clock. Each step has exactly one bus source, any number of bus destinations, an optional memory request and an optional wait. The ALU takes its first operand from a staging register Y or from the constant 4, and its second operand from the bus. The result is captured in a holding register Z and moves back onto the bus in a later step.

The core reaches external memory only through its address register (driven onto `mem_addr`) and its data register (driven onto `mem_wdata`, loaded from `mem_rdata`). It uses a read line, a write line and a memory-function-complete input. A request rises one clock after the step that issues it. It then stays up, with address and write data held still, until the cycle in which `mem_mfc` is high, and it drops in the following cycle. Memory supplies read data in that same `mem_mfc` cycle. Memory must pulse `mem_mfc` for a single cycle, and only while a request is up. The core's back-pressure is this wait alone: the step counter holds in any waiting step until completion arrives, while the step's other transfers repeat harmlessly.

Five operations are decoded: add of two registers, add of a memory word addressed by a register, load, store, and a relative branch. Any other opcode finishes right after the fetch.

Top module: `sbus_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both `mem_read` and `mem_write` are low. The program counter, instruction register and all eight 32-bit registers start at zero.
- R2: Each instruction is fetched by a read at the program counter's address, and the program counter grows by 4 before the instruction executes. The first read after reset appears one cycle after release, at address 0.
- R3: A raised `mem_read` or `mem_write` stays high, with `mem_addr` (and for writes `mem_wdata`) unchanged, until a cycle with `mem_mfc` high. It is low in the next cycle, and the step counter does not leave a waiting step before `mem_mfc`.
- R4: `mem_read` and `mem_write` are never high together.
- R5: Opcode bits [31:26] = 0x01 writes reg[a] = reg[b] + reg[c], with field a in bits [25:23], b in [22:20] and c in [19:17].
- R6: Opcode 0x02 writes reg[a] = reg[a] + mem[reg[b]].
- R7: Opcode 0x03 writes reg[a] = mem[reg[b]]. Bits [19:0] play no part.
- R8: Opcode 0x04 performs one write of reg[a] to address reg[b]. No other memory word changes.
- R9: Opcode 0x05 sets the program counter to the branch's address + 4 + the sign-extended bits [15:0]. An offset of -4 (0xFFFC) repeats the branch forever.
- R10: Any other opcode changes no register and no memory word, and the next fetch follows at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address from the address register |
| mem_wdata | output | 32 | Write data from the data register |
| mem_rdata | input | 32 | Read data, sampled in the completion cycle |
| mem_read | output | 1 | Read request, held until completion |
| mem_write | output | 1 | Write request, held until completion |
| mem_mfc | input | 1 | Memory function complete, one-cycle pulse |

## Verification
The assertions check the memory handshake on every cycle: requests hold with a stable address and data until completion and then drop, reads and writes stay exclusive, the fetch wait step holds until completion, and each fetch advances the program counter by exactly one word. The arithmetic results, the register-indirect addressing, the skipped instruction behind a forward branch, the self-loop of a backward branch and the inertness of an unknown opcode show only in the bench's program runs. Those runs sweep the memory latency from one to four cycles over several data sets and compare final memory words with values computed from the instruction semantics.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int OP_W   = 6;
  localparam int RIDX_W = 3;
  localparam int NREG   = 1 << RIDX_W;

  localparam logic [OP_W-1:0] OPC_ADD  = 6'h01;
  localparam logic [OP_W-1:0] OPC_ADDM = 6'h02;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'h03;
  localparam logic [OP_W-1:0] OPC_STOR = 6'h04;
  localparam logic [OP_W-1:0] OPC_BRA  = 6'h05;

  typedef enum logic [2:0] {
    BS_NONE, BS_PC, BS_Z, BS_MDR, BS_REG, BS_OFS
  } bus_src_e;

  typedef struct packed {
    bus_src_e            src;
    logic [RIDX_W-1:0]   rsel;
    logic [RIDX_W-1:0]   wsel;
    logic                rf_in;
    logic                pc_in;
    logic                mar_in;
    logic                mdr_in;
    logic                ir_in;
    logic                y_in;
    logic                z_in;
    logic                sel4;
    logic                rd_req;
    logic                wr_req;
    logic                wmfc;
    logic                done;
  } ctl_t;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [XLEN-1:0]         rd_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [XLEN-1:0]         wr_data
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en && wr_idx == g) regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int XLEN = 32
) (
  input  logic            sel_four,
  input  logic [XLEN-1:0] y_val,
  input  logic [XLEN-1:0] bus_val,
  output logic [XLEN-1:0] sum
);
  localparam int WORD_BYTES = XLEN / 8;
  logic [XLEN-1:0] opa;

  assign opa = sel_four ? XLEN'(WORD_BYTES) : y_val;
  assign sum = opa + bus_val;
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic [RIDX_W-1:0] fa,
  input  logic [RIDX_W-1:0] fb,
  input  logic [RIDX_W-1:0] fc,
  input  logic              mem_mfc,
  output ctl_t              ctl,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] ST_F0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] ST_F1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_F2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_E0 = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_E1 = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_E2 = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_E3 = STEP_W'(6);

  logic [STEP_W-1:0] step_q;
  logic              hold;

  always_comb begin
    ctl = '0;
    case (step_q)
      ST_F0: begin
        ctl.src = BS_PC; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
        ctl.sel4 = 1'b1; ctl.z_in = 1'b1;
      end
      ST_F1: begin
        ctl.src = BS_Z; ctl.pc_in = 1'b1; ctl.y_in = 1'b1; ctl.wmfc = 1'b1;
      end
      ST_F2: begin
        ctl.src = BS_MDR; ctl.ir_in = 1'b1;
      end
      default: begin
        case (op)
          OPC_ADD: begin
            case (step_q)
              ST_E0: begin ctl.src = BS_REG; ctl.rsel = fb; ctl.y_in = 1'b1; end
              ST_E1: begin ctl.src = BS_REG; ctl.rsel = fc; ctl.z_in = 1'b1; end
              ST_E2: begin
                ctl.src = BS_Z; ctl.rf_in = 1'b1; ctl.wsel = fa; ctl.done = 1'b1;
              end
              default: ctl.done = 1'b1;
            endcase
          end
          OPC_ADDM: begin
            case (step_q)
              ST_E0: begin
                ctl.src = BS_REG; ctl.rsel = fb; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
              end
              ST_E1: begin
                ctl.src = BS_REG; ctl.rsel = fa; ctl.y_in = 1'b1; ctl.wmfc = 1'b1;
              end
              ST_E2: begin ctl.src = BS_MDR; ctl.z_in = 1'b1; end
              ST_E3: begin
                ctl.src = BS_Z; ctl.rf_in = 1'b1; ctl.wsel = fa; ctl.done = 1'b1;
              end
              default: ctl.done = 1'b1;
            endcase
          end
          OPC_LOAD: begin
            case (step_q)
              ST_E0: begin
                ctl.src = BS_REG; ctl.rsel = fb; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
              end
              ST_E1: ctl.wmfc = 1'b1;
              ST_E2: begin
                ctl.src = BS_MDR; ctl.rf_in = 1'b1; ctl.wsel = fa; ctl.done = 1'b1;
              end
              default: ctl.done = 1'b1;
            endcase
          end
          OPC_STOR: begin
            case (step_q)
              ST_E0: begin ctl.src = BS_REG; ctl.rsel = fb; ctl.mar_in = 1'b1; end
              ST_E1: begin
                ctl.src = BS_REG; ctl.rsel = fa; ctl.mdr_in = 1'b1; ctl.wr_req = 1'b1;
              end
              ST_E2: begin ctl.wmfc = 1'b1; ctl.done = 1'b1; end
              default: ctl.done = 1'b1;
            endcase
          end
          OPC_BRA: begin
            case (step_q)
              ST_E0: begin ctl.src = BS_PC; ctl.y_in = 1'b1; end
              ST_E1: begin ctl.src = BS_OFS; ctl.z_in = 1'b1; end
              ST_E2: begin
                ctl.src = BS_Z; ctl.pc_in = 1'b1; ctl.done = 1'b1;
              end
              default: ctl.done = 1'b1;
            endcase
          end
          default: ctl.done = 1'b1;
        endcase
      end
    endcase
  end

  // a waiting step holds (its other transfers repeat) until completion
  assign hold = ctl.wmfc && !mem_mfc;

  always_ff @(posedge clk) begin
    if (!rst_n)                 step_q <= ST_F0;
    else if (ctl.done && !hold) step_q <= ST_F0;
    else if (!hold)             step_q <= step_q + STEP_W'(1);
  end

  assign step = step_q;
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int STEP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_read,
  output logic            mem_write,
  input  logic            mem_mfc
);
  localparam int OFS_W = 16;

  ctl_t              ctl;
  logic [STEP_W-1:0] step_w;
  logic [XLEN-1:0]   pc_q, ir_q, mar_q, mdr_q, y_q, z_q;
  logic              rd_pend, wr_pend;
  logic [XLEN-1:0]   bus, rf_rdata, alu_sum, ofs_ext;
  logic              unused_ir_bit;

  assign unused_ir_bit = ir_q[16];
  assign ofs_ext = {{(XLEN-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};

  sbus_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ir_q[31:26]),
    .fa      (ir_q[25:23]),
    .fb      (ir_q[22:20]),
    .fc      (ir_q[19:17]),
    .mem_mfc (mem_mfc),
    .ctl     (ctl),
    .step    (step_w)
  );

  sbus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ctl.rsel),
    .rd_data (rf_rdata),
    .wr_en   (ctl.rf_in),
    .wr_idx  (ctl.wsel),
    .wr_data (bus)
  );

  sbus_alu #(.XLEN(XLEN)) u_alu (
    .sel_four (ctl.sel4),
    .y_val    (y_q),
    .bus_val  (bus),
    .sum      (alu_sum)
  );

  // single shared bus: one source per step
  always_comb begin
    case (ctl.src)
      BS_PC:   bus = pc_q;
      BS_Z:    bus = z_q;
      BS_MDR:  bus = mdr_q;
      BS_REG:  bus = rf_rdata;
      BS_OFS:  bus = ofs_ext;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; mar_q <= '0; mdr_q <= '0;
      y_q <= '0; z_q <= '0; rd_pend <= 1'b0; wr_pend <= 1'b0;
    end else begin
      if (ctl.pc_in)  pc_q  <= bus;
      if (ctl.ir_in)  ir_q  <= bus;
      if (ctl.mar_in) mar_q <= bus;
      if (ctl.y_in)   y_q   <= bus;
      if (ctl.z_in)   z_q   <= alu_sum;
      if (rd_pend && mem_mfc) mdr_q <= mem_rdata;
      else if (ctl.mdr_in)    mdr_q <= bus;
      if (ctl.rd_req)   rd_pend <= 1'b1;
      else if (mem_mfc) rd_pend <= 1'b0;
      if (ctl.wr_req)   wr_pend <= 1'b1;
      else if (mem_mfc) wr_pend <= 1'b0;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_read  = rd_pend;
  assign mem_write = wr_pend;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int XLEN   = 32,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_wdata,
  input logic              mem_read,
  input logic              mem_write,
  input logic              mem_mfc,
  input logic [STEP_W-1:0] step,
  input logic [XLEN-1:0]   pc
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read && !mem_mfc |=> mem_read && $stable(mem_addr)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write && !mem_mfc |=> mem_write && $stable(mem_addr) && $stable(mem_wdata)); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read || mem_write) && mem_mfc |=> !(mem_read || mem_write)); // R3
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(1)) && !mem_mfc |=> step == STEP_W'(1)); // R3
  AST_EXCL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write)); // R4
  AST_PC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    step == '0 |=> ##1 (pc == $past(pc, 2) + XLEN'(4))); // R2
endmodule

bind sbus_core sbus_core_chk #(.XLEN(XLEN), .STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_read  (mem_read),
  .mem_write (mem_write),
  .mem_mfc   (mem_mfc),
  .step      (step_w),
  .pc        (pc_q)
);

// File: tb/sbus_core_bench.sv
module sbus_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_read, mem_write;
  logic        mem_mfc;

  logic [31:0] mem [64];
  logic [2:0]  cnt;
  int          lat = 1;
  logic        do_load = 1'b0;
  logic [31:0] seed = '0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;
  int          r3_bad = 0, r4_bad = 0;
  logic        p_rd, p_wr, p_mfc, p_ok;
  logic [31:0] p_addr, p_wdata;

  always #4 clk = ~clk;

  sbus_core u_sbus_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_read(mem_read), .mem_write(mem_write),
    .mem_mfc(mem_mfc)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [2:0] c,
                                      input logic [15:0] off);
    return {op, a, b, c, 1'b0, off};
  endfunction

  function automatic logic [31:0] d40(input logic [31:0] s);
    logic [31:0] h = s * 32'h9E37_79B1 + 32'h1234_5678;
    return {h[23:0], 8'hA4};
  endfunction

  function automatic logic [31:0] d41(input logic [31:0] s);
    logic [31:0] h = s * 32'h85EB_CA6B + 32'h0BAD_F00D;
    return {h[31:8], 8'h0C};
  endfunction

  function automatic logic [31:0] init_word(input int i, input logic [31:0] s);
    case (i)
      0:  return enc(6'h03, 3'd1, 3'd0, 3'd0, 16'h00A0);
      1:  return enc(6'h03, 3'd2, 3'd1, 3'd0, 16'h0);
      2:  return enc(6'h03, 3'd3, 3'd2, 3'd0, 16'h0);
      3:  return enc(6'h01, 3'd4, 3'd2, 3'd1, 16'h0);
      4:  return enc(6'h02, 3'd3, 3'd1, 3'd0, 16'h0);
      5:  return enc(6'h05, 3'd0, 3'd0, 3'd0, 16'h0004);
      6:  return enc(6'h01, 3'd4, 3'd4, 3'd4, 16'h0);
      7:  return 32'hFDB6_1234;
      8:  return enc(6'h01, 3'd5, 3'd4, 3'd4, 16'h0);
      9:  return enc(6'h02, 3'd5, 3'd2, 3'd0, 16'h0);
      10: return enc(6'h04, 3'd4, 3'd0, 3'd0, 16'h0);
      11: return enc(6'h04, 3'd3, 3'd1, 3'd0, 16'h0);
      12: return enc(6'h04, 3'd5, 3'd2, 3'd0, 16'h0);
      13: return enc(6'h04, 3'd2, 3'd3, 3'd0, 16'h0);
      14: return enc(6'h05, 3'd0, 3'd0, 3'd0, 16'hFFFC);
      40: return d40(s);
      41: return d41(s);
      default: return 32'h5A5A_0000 ^ (i * 32'h0101_0101) ^ s;
    endcase
  endfunction

  assign mem_rdata = mem[mem_addr[7:2]];

  // memory responder: one-cycle completion pulse after lat cycles of request
  always @(posedge clk) begin
    if (do_load) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i, seed);
    end
    if (!rst_n) begin
      mem_mfc <= 1'b0; cnt <= '0;
    end else if (!(mem_read || mem_write)) begin
      mem_mfc <= 1'b0; cnt <= '0;
    end else if (mem_mfc) begin
      mem_mfc <= 1'b0; cnt <= '0;
      if (mem_write) mem[mem_addr[7:2]] <= mem_wdata;
    end else begin
      cnt <= cnt + 3'd1;
      mem_mfc <= (int'(cnt) == lat - 1);
    end
  end

  // handshake monitor (R3, R4)
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ok <= 1'b0;
    end else begin
      if (p_ok && p_rd && !p_mfc && !(mem_read && mem_addr == p_addr)) r3_bad <= r3_bad + 1;
      if (p_ok && p_wr && !p_mfc && !(mem_write && mem_addr == p_addr && mem_wdata == p_wdata))
        r3_bad <= r3_bad + 1;
      if (p_ok && (p_rd || p_wr) && p_mfc && (mem_read || mem_write)) r3_bad <= r3_bad + 1;
      if (mem_read && mem_write) r4_bad <= r4_bad + 1;
      p_ok <= 1'b1; p_rd <= mem_read; p_wr <= mem_write; p_mfc <= mem_mfc;
      p_addr <= mem_addr; p_wdata <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input int l, input logic [31:0] s);
    logic [31:0] e0, a, b, x0, x40, x41, x44;
    int bad, guard;
    @(negedge clk);
    rst_n = 1'b0; lat = l; seed = s; do_load = 1'b1;
    @(negedge clk);
    do_load = 1'b0;
    repeat (3) @(negedge clk);
    r3_bad = 0; r4_bad = 0;
    rst_n = 1'b1;
    check(!mem_read && !mem_write, "R1 quiet after reset", {30'd0, mem_read, mem_write}, 32'd0);
    @(negedge clk);
    check(mem_read && mem_addr == 32'd0, "R2 first fetch at 0", mem_addr, 32'd0);
    repeat (700) @(negedge clk);
    guard = 0;
    while (!mem_read && guard < 60) begin @(negedge clk); guard++; end
    check(mem_read && mem_addr == 32'd56, "R9 backward branch self-loop", mem_addr, 32'd56);
    e0 = init_word(0, s); a = d40(s); b = d41(s);
    x0 = a + e0; x40 = a + b; x41 = 2 * (a + e0) + b; x44 = a;
    check(mem[0] == x0, "R5 R9 word0 register add after skip", mem[0], x0);
    check(mem[40] == x40, "R6 word40 memory add", mem[40], x40);
    check(mem[41] == x41, "R6 R10 word41 after unknown opcode", mem[41], x41);
    check(mem[44] == x44, "R7 R8 word44 load then store", mem[44], x44);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (i != 0 && i != 40 && i != 41 && i != 44 && mem[i] != init_word(i, s)) bad++;
    check(bad == 0, "R8 R10 untouched words", bad, 32'd0);
    check(r3_bad == 0, "R3 request held until completion", r3_bad, 32'd0);
    check(r4_bad == 0, "R4 read/write exclusive", r4_bad, 32'd0);
  endtask

  initial begin
    for (int l = 1; l <= 4; l++)
      for (int k = 0; k < 3; k++)
        run(l, 32'h0000_1000 * k + 32'h37 * l);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule